// File: doc/BRIEF.md
# Scanline-Prescaled IRQ Counter

This block raises a level interrupt after a programmable number of timing ticks. An 8-bit counter counts upward from a reload value. When it passes 0xFF it reloads and asserts the interrupt. Ticks come from one of two sources. In cycle mode, every CPU-cycle strobe is a tick. In scanline mode, a signed prescaler spends a budget of 341 in steps of 3, one step per CPU cycle. This matches the ratio of three video dots to one CPU cycle, so the counter advances about once per 341-dot video line.

Software programs the block through a narrow write port selected by a two-bit sub-address:

- Two sub-addresses load the reload latch one nibble at a time.
- A third sub-address holds the control bits: repeat, enable and mode. A control write with the enable bit set also restarts the counter and the prescaler.
- The fourth sub-address acknowledges the interrupt. When the `REPEAT_EN` parameter is set, the acknowledge also copies the repeat bit into the enable bit.

The run control is a three-state machine:

- **HALT**: no counting.
- **LINE**: scanline-prescaled counting.
- **CYCLE**: direct CPU-cycle counting.

The state machine has three transitions:

- **CTRL_WRITE**: any state goes to HALT, LINE or CYCLE according to control bits 1 and 2.
- **ACK_REARM**: when `REPEAT_EN` is set, any state goes to HALT when the stored repeat bit is 0. When the repeat bit is 1, it goes to LINE or CYCLE according to the stored mode bit.
- **HOLD**: with no write, or with an acknowledge when `REPEAT_EN` is clear, the state stays unchanged.

Top module: `irq_line_counter`

## Requirements
- R1: After reset, `irq` is low, the latch, counter, prescaler and control bits are zero, and the run state is HALT. No number of `cpu_tick` strobes raises `irq` until the block is enabled.
- R2: A write to sub-address 0 loads latch bits [3:0] from `wr_data[3:0]`. Bits [7:4] of the data are ignored.
- R3: A write to sub-address 1 loads latch bits [7:4] from `wr_data[3:0]`. Bits [7:4] of the data are ignored.
- R4: A write to sub-address 2 stores three control bits: bit 0 is repeat, bit 1 is enable, and bit 2 is mode (1 = cycle, 0 = scanline). When bit 1 is set, the counter is reloaded from the latch and the prescaler is set to 341.
- R5: A write to sub-address 2 with bit 1 clear stops counting. It leaves the counter and prescaler values unchanged.
- R6: In cycle mode, each `cpu_tick` strobe increments the counter. With latch value L, the interrupt rises on strobe 256-L after the enabling write.
- R7: In scanline mode, each strobe subtracts 3 from the signed prescaler. A counter tick occurs when the result is at most 0, and 341 is then added back. Starting from 341, ticks therefore fall after 114, 114 and then 113 strobes.
- R8: When a tick carries the counter from 0xFF to 0, the counter reloads from the latch and `irq` rises. `irq` is a level that stays high until a write to sub-address 2 or 3.
- R9: Any write to sub-address 2 or 3 releases `irq`. With `REPEAT_EN`=1, a write to sub-address 3 also copies the stored repeat bit into the enable bit, and it reloads nothing.
- R10: With `REPEAT_EN`=0, a write to sub-address 3 only releases `irq` and leaves the run state unchanged.
- R11: In a cycle where `wr_en` is high, a simultaneous `cpu_tick` is not counted by either the counter or the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register sub-address (0 latch low, 1 latch high, 2 control, 3 acknowledge) |
| wr_data | input | 8 | Write data |
| cpu_tick | input | 1 | One-cycle strobe per CPU cycle |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds two copies of the block side by side on the same stimulus, both with the default 8-bit counter, a 10-bit prescaler, a budget of 341 and a step of 3. One copy has `REPEAT_EN`=1 and the other has `REPEAT_EN`=0. The pair lets a single acknowledge write show both outcomes: the first copy re-enables or stops according to the stored repeat bit, while the second copy's run state is left as it was. The default budget and step give overflow points of 228 and 227 strobes, which is short enough to cover the full 114/114/113 scanline rhythm and the reload after overflow.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_LINE  = 2'd1,
        ST_CYCLE = 2'd2
    } run_state_t;

    localparam logic [1:0] SEL_LAT_LO = 2'd0;
    localparam logic [1:0] SEL_LAT_HI = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;
    localparam logic [1:0] SEL_ACK    = 2'd3;

    localparam int CTL_REPEAT = 0;
    localparam int CTL_ENABLE = 1;
    localparam int CTL_MODE   = 2;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
    import irqc_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int DATA_W    = 8,
    parameter bit REPEAT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  latch,
    output logic              reload,
    output logic              irq_clr,
    output logic              line_run,
    output logic              cycle_run
);
    localparam int HALF = CNT_W / 2;

    run_state_t state_q, state_d;
    logic       rep_q, mode_q;
    logic       wr_ctrl, wr_ack;
    logic       unused_data;

    assign wr_ctrl     = wr_en && (wr_sel == SEL_CTRL);
    assign wr_ack      = wr_en && (wr_sel == SEL_ACK);
    assign unused_data = ^wr_data[DATA_W-1:HALF];

    // Latch nibbles and stored control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch  <= '0;
            rep_q  <= 1'b0;
            mode_q <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_LAT_LO: latch[HALF-1:0]     <= wr_data[HALF-1:0];
                SEL_LAT_HI: latch[CNT_W-1:HALF] <= wr_data[HALF-1:0];
                SEL_CTRL: begin
                    rep_q  <= wr_data[CTL_REPEAT];
                    mode_q <= wr_data[CTL_MODE];
                end
                default: ;
            endcase
        end
    end

    // Next-state logic: CTRL_WRITE, ACK_REARM, HOLD
    always_comb begin
        state_d = state_q;
        if (wr_ctrl) begin
            if (wr_data[CTL_ENABLE])
                state_d = wr_data[CTL_MODE] ? ST_CYCLE : ST_LINE;
            else
                state_d = ST_HALT;
        end else if (wr_ack && REPEAT_EN) begin
            if (rep_q)
                state_d = mode_q ? ST_CYCLE : ST_LINE;
            else
                state_d = ST_HALT;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        line_run  = 1'b0;
        cycle_run = 1'b0;
        unique case (state_q)
            ST_HALT:  ;
            ST_LINE:  line_run  = 1'b1;
            ST_CYCLE: cycle_run = 1'b1;
            default:  ;
        endcase
        reload  = wr_ctrl && wr_data[CTL_ENABLE];
        irq_clr = wr_ctrl || wr_ack;
    end
endmodule

// File: rtl/irqc_prescaler.sv
module irqc_prescaler #(
    parameter int PS_W   = 10,
    parameter int BUDGET = 341,
    parameter int STEP   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   step_en,
    output logic                   tick,
    output logic signed [PS_W-1:0] level
);
    localparam logic signed [PS_W-1:0] BUD_S  = PS_W'(BUDGET);
    localparam logic signed [PS_W-1:0] STEP_S = PS_W'(STEP);

    logic signed [PS_W-1:0] after_step;

    assign after_step = level - STEP_S;
    assign tick       = step_en && (after_step <= 0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       level <= '0;
        else if (load)    level <= BUD_S;
        else if (tick)    level <= after_step + BUD_S;
        else if (step_en) level <= after_step;
    end
endmodule

// File: rtl/irqc_counter.sv
module irqc_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic             irq_clr,
    input  logic [CNT_W-1:0] latch,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = tick && (cnt_q == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            if (load || wrap) cnt_q <= latch;
            else if (tick)    cnt_q <= cnt_q + 1'b1;

            if (irq_clr)   irq <= 1'b0;
            else if (wrap) irq <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
    parameter int CNT_W     = 8,
    parameter int DATA_W    = 8,
    parameter int PS_W      = 10,
    parameter int BUDGET    = 341,
    parameter int STEP      = 3,
    parameter bit REPEAT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cpu_tick,
    output logic              irq
);
    logic [CNT_W-1:0]       latch;
    logic                   reload, irq_clr, line_run, cycle_run;
    logic                   ps_tick, cnt_tick, cpu_free;
    logic signed [PS_W-1:0] ps_level;

    assign cpu_free = cpu_tick && !wr_en;
    assign cnt_tick = ps_tick || (cpu_free && cycle_run);

    irqc_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W), .REPEAT_EN(REPEAT_EN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .latch(latch), .reload(reload), .irq_clr(irq_clr),
        .line_run(line_run), .cycle_run(cycle_run)
    );

    irqc_prescaler #(.PS_W(PS_W), .BUDGET(BUDGET), .STEP(STEP)) u_ps (
        .clk(clk), .rst_n(rst_n), .load(reload), .step_en(cpu_free && line_run),
        .tick(ps_tick), .level(ps_level)
    );

    irqc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(reload), .tick(cnt_tick),
        .irq_clr(irq_clr), .latch(latch), .irq(irq)
    );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int PS_W   = 10,
    parameter int BUDGET = 341
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [1:0]             wr_sel,
    input logic [7:0]             wr_data,
    input logic                   cpu_tick,
    input logic                   irq,
    input logic signed [PS_W-1:0] ps_level
);
    AST_RESET_IRQ_LOW: assert property (@(posedge clk) !rst_n |=> !irq); // R1
    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel[1] |=> !irq); // R9
    AST_IRQ_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(wr_en && wr_sel[1]) |=> irq); // R8
    AST_RISE_NEEDS_FREE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cpu_tick && !wr_en)); // R11
    AST_PS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'd2 && wr_data[1] |=> ps_level == PS_W'(BUDGET)); // R4
    AST_PS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ps_level >= 0 && ps_level <= PS_W'(BUDGET)); // R7
endmodule

bind irq_line_counter irqc_checker #(.PS_W(PS_W), .BUDGET(BUDGET)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cpu_tick(cpu_tick), .irq(irq), .ps_level(ps_level)
);

// File: tb/tb_irq_line_counter.sv
module tb_irq_line_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       cpu_tick = 1'b0;
    logic       irq, irq_nr;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    irq_line_counter #(.REPEAT_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cpu_tick(cpu_tick), .irq(irq));
    irq_line_counter #(.REPEAT_EN(1'b0)) dut_norep (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cpu_tick(cpu_tick), .irq(irq_nr));

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: irq actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d, input logic tk = 1'b0);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; cpu_tick = tk;
        @(negedge clk);
        wr_en = 1'b0; cpu_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cpu_tick = 1'b1;
            @(negedge clk);
        end
        cpu_tick = 1'b0;
    endtask

    task automatic set_latch(input logic [7:0] lo_d, input logic [7:0] hi_d);
        wr(2'd0, lo_d);
        wr(2'd1, hi_d);
    endtask

    task automatic t_reset();
        check("R1 reset", irq, 1'b0);
        ticks(300);
        check("R1 disabled after reset", irq, 1'b0);
    endtask

    task automatic t_nibbles();
        // R2/R3: data 0x5E low -> E, 0x3F high -> F; latch 0xFE -> 2 ticks
        set_latch(8'h5E, 8'h3F);
        wr(2'd2, 8'h06);
        ticks(1);
        check("R2 one tick short", irq, 1'b0);
        ticks(1);
        check("R3 latch FE overflow", irq, 1'b1);
        check("R3 norep copy", irq_nr, 1'b1);
    endtask

    task automatic t_cycle_reload();
        // R6/R8: latch F0 -> 16 ticks; reload after overflow
        set_latch(8'hA0, 8'hFF);
        wr(2'd2, 8'h07);
        check("R9 ctrl write releases", irq, 1'b0);
        ticks(15);
        check("R6 15 of 16", irq, 1'b0);
        ticks(1);
        check("R6 16 ticks", irq, 1'b1);
        ticks(20);
        check("R8 level held", irq, 1'b1);
        wr(2'd3, 8'h00);
        check("R9 ack releases", irq, 1'b0);
        check("R9 ack releases norep", irq_nr, 1'b0);
        // counter was reloaded at overflow and ran 20 -> currently F0+4=F4 (wraps again at 16th -> F0, +4)
        ticks(11);
        check("R8 reload next-1", irq, 1'b0);
        ticks(1);
        check("R8 reload period", irq, 1'b1);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_stop_repeat();
        // R5/R9/R10: latch FD; 1 tick, stop with repeat set, ack
        set_latch(8'h0D, 8'h0F);
        wr(2'd2, 8'h07);
        ticks(1);
        wr(2'd2, 8'h05);
        ticks(50);
        check("R5 stopped", irq, 1'b0);
        wr(2'd3, 8'h00);
        ticks(1);
        check("R5 no reload on stop", irq, 1'b0);
        ticks(1);
        check("R9 repeat re-enabled", irq, 1'b1);
        check("R10 norep stays halted", irq_nr, 1'b0);
        wr(2'd2, 8'h04);
        wr(2'd3, 8'h00);
        ticks(300);
        check("R9 repeat 0 halts", irq, 1'b0);
    endtask

    task automatic t_write_suppress();
        set_latch(8'h0E, 8'h0F);
        wr(2'd2, 8'h06);
        wr(2'd0, 8'h0E, 1'b1);
        wr(2'd0, 8'h0E, 1'b1);
        check("R11 writes not counted", irq, 1'b0);
        ticks(2);
        check("R11 two free ticks", irq, 1'b1);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_scanline();
        set_latch(8'h0E, 8'h0F);
        wr(2'd2, 8'h03);
        ticks(227);
        check("R7 227 strobes", irq, 1'b0);
        ticks(1);
        check("R7 228 strobes", irq, 1'b1);
        check("R7 norep", irq_nr, 1'b1);
        wr(2'd3, 8'h00);
        ticks(226);
        check("R7 113+113", irq, 1'b0);
        ticks(1);
        check("R7 113+114", irq, 1'b1);
        check("R7 norep second", irq_nr, 1'b1);
        wr(2'd2, 8'h00);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nibbles();
        wr(2'd2, 8'h00);
        t_cycle_reload();
        t_stop_repeat();
        t_write_suppress();
        t_scanline();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule